// File: doc/BRIEF.md
# LCD Scanline Timing Controller

This block produces the line and frame timing for a 240 by 160 display from a single system clock. It steps through three phases: active drawing, horizontal blank and vertical blank. It keeps the number of the current scanline and holds a 16-bit status word. That word carries the blank flags, a line-compare flag, three interrupt enables and an 8-bit compare line.

Interrupt events leave the block as one-cycle pulses, and an interrupt controller elsewhere on the chip collects them. A render strobe marks the start of each visible line, so a pixel pipeline can fetch that line. The line number advances when horizontal blank ends rather than when the line begins. Each such advance checks the compare line again, and this includes the blank lines and the return to line 0.

Top module: `lcd_scan_timer`

## Requirements
- R1: After reset the controller is in the draw phase (state code 0) at line 0. The status word reads 0x0000, and no interrupt or render strobe is active.
- R2: The draw phase lasts PIX_CYC*H_PIXELS clock cycles (960 by default), and then the state becomes horizontal blank (code 1).
- R3: On entry to horizontal blank, status bit 1 is set. If status bit 4 is set, `irq_hblank` pulses high for exactly one cycle in the first cycle of horizontal blank. If bit 4 is clear, there is no pulse.
- R4: Horizontal blank lasts HB_CYC cycles. When it ends, status bit 1 clears and the line number rises by one. If the new line is below V_LINES, the state returns to draw and `render_stb` pulses for one cycle.
- R5: If the line reached at the end of horizontal blank equals V_LINES, the state becomes vertical blank (code 2) and status bit 0 is set. `irq_vblank` pulses if status bit 3 is set. No render strobe is given.
- R6: Each vertical-blank line lasts PIX_CYC*H_PIXELS+HB_CYC cycles. After line V_LINES+VB_LINES-1 the line wraps to 0, bit 0 clears, `render_stb` pulses and the state returns to draw. Vertical blank therefore spans VB_LINES full line periods.
- R7: Each time the line number changes, status bit 2 is set if the new line equals status bits 15:8, and is cleared otherwise. A compare value written in the same cycle as a line change takes effect from the next change.
- R8: When a line change sets status bit 2 and status bit 5 is set, `irq_vmatch` pulses for one cycle. This holds on visible lines, on vertical-blank lines and on the wrap to line 0. No pulse occurs while bit 5 is clear.
- R9: A write (`wr_en`) loads status bits 5:3 and 15:8 from `wr_data`. It leaves bits 2:0 unchanged, and bits 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Status write value |
| status | output | 16 | Status readback |
| line | output | 8 | Current scanline number |
| state | output | 2 | Phase: 0 draw, 1 horizontal blank, 2 vertical blank |
| irq_hblank | output | 1 | Horizontal-blank interrupt pulse |
| irq_vblank | output | 1 | Vertical-blank interrupt pulse |
| irq_vmatch | output | 1 | Line-compare interrupt pulse |
| render_stb | output | 1 | Start-of-visible-line render strobe |

## Verification
The bench shrinks the panel geometry through parameters so that whole frames fit in a short run.

The compare tests target a match on a vertical-blank line and a match on the wrap to line 0. A design that updated the compare flag only on visible lines, or skipped the check on the wrap, would miss those pulses.

Phase lengths are measured in cycles. An off-by-one at a phase end would add or lose a cycle on every line, and an extra or missing blank line would change the cycle count of the vertical-blank stretch.

Status writes made during horizontal blank test that the hardware-owned flags survive a CPU write of all ones or all zeros.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int PIX_CYC  = 4,
  parameter int H_PIXELS = 240,
  parameter int V_LINES  = 160,
  parameter int VB_LINES = 68,
  parameter int HB_CYC   = 272
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] status,
  output logic [7:0]  line,
  output logic [1:0]  state,
  output logic        irq_hblank,
  output logic        irq_vblank,
  output logic        irq_vmatch,
  output logic        render_stb
);
  localparam int HDRAW_CYC   = PIX_CYC * H_PIXELS;
  localparam int LINE_CYC    = HDRAW_CYC + HB_CYC;
  localparam int TOTAL_LINES = V_LINES + VB_LINES;
  localparam int CW          = $clog2(LINE_CYC + 1);

  localparam logic [CW-1:0] HD_LAST = CW'(HDRAW_CYC - 1);
  localparam logic [CW-1:0] HB_LAST = CW'(HB_CYC - 1);
  localparam logic [CW-1:0] LN_LAST = CW'(LINE_CYC - 1);
  localparam logic [7:0]    VIS_END = 8'(V_LINES);
  localparam logic [7:0]    FR_LAST = 8'(TOTAL_LINES - 1);

  localparam logic [1:0] S_DRAW = 2'd0;
  localparam logic [1:0] S_HBL  = 2'd1;
  localparam logic [1:0] S_VBL  = 2'd2;

  logic [1:0]    st;
  logic [CW-1:0] cyc;
  logic [7:0]    ln;
  logic          vbl_f, hbl_f, cmp_f;
  logic [2:0]    en;
  logic [7:0]    cmp_ln;
  logic          wrap;
  logic [7:0]    nxt;
  logic          hit;

  assign wrap = (st == S_VBL) && (ln == FR_LAST);
  assign nxt  = wrap ? 8'd0 : ln + 8'd1;
  assign hit  = (nxt == cmp_ln);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_DRAW;
      cyc        <= '0;
      ln         <= '0;
      vbl_f      <= 1'b0;
      hbl_f      <= 1'b0;
      cmp_f      <= 1'b0;
      en         <= '0;
      cmp_ln     <= '0;
      irq_hblank <= 1'b0;
      irq_vblank <= 1'b0;
      irq_vmatch <= 1'b0;
      render_stb <= 1'b0;
    end else begin
      irq_hblank <= 1'b0;
      irq_vblank <= 1'b0;
      irq_vmatch <= 1'b0;
      render_stb <= 1'b0;
      if (wr_en) begin
        en     <= wr_data[5:3];
        cmp_ln <= wr_data[15:8];
      end
      case (st)
        S_DRAW: begin
          if (cyc == HD_LAST) begin
            cyc        <= '0;
            st         <= S_HBL;
            hbl_f      <= 1'b1;
            irq_hblank <= en[1];
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        S_HBL: begin
          if (cyc == HB_LAST) begin
            cyc        <= '0;
            hbl_f      <= 1'b0;
            ln         <= nxt;
            cmp_f      <= hit;
            irq_vmatch <= hit & en[2];
            if (nxt < VIS_END) begin
              st         <= S_DRAW;
              render_stb <= 1'b1;
            end else begin
              st         <= S_VBL;
              vbl_f      <= 1'b1;
              irq_vblank <= en[0];
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: begin
          if (cyc == LN_LAST) begin
            cyc        <= '0;
            ln         <= nxt;
            cmp_f      <= hit;
            irq_vmatch <= hit & en[2];
            if (wrap) begin
              st         <= S_DRAW;
              vbl_f      <= 1'b0;
              render_stb <= 1'b1;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
      endcase
    end
  end

  assign status = {cmp_ln, 2'b00, en, cmp_f, hbl_f, vbl_f};
  assign line   = ln;
  assign state  = st;
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
  parameter int V_LINES     = 160,
  parameter int TOTAL_LINES = 228
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] status,
  input logic [7:0]  line,
  input logic [1:0]  state,
  input logic        irq_hblank,
  input logic        irq_vblank,
  input logic        irq_vmatch,
  input logic        render_stb
);
  p_line_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (int'(line) < TOTAL_LINES) && (state != 2'd3));

  p_hbl_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((state == 2'd1) == status[1]));

  p_hbl_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hblank |=> !irq_hblank);

  p_hbl_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hblank |-> (state == 2'd1) && $past(state) == 2'd0 && $past(status[4]));

  p_render_r4: assert property (@(posedge clk) disable iff (!rst_n)
    render_stb |-> (state == 2'd0) && (int'(line) < V_LINES) && $past(state) != 2'd0);

  p_vbl_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((state == 2'd2) == status[0]));

  p_vbl_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vblank |-> (state == 2'd2) && $past(state) == 2'd1 && int'(line) == V_LINES);

  p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line != $past(line)) |-> (line == $past(line) + 8'd1) || (line == 8'd0));

  p_cmp_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line != $past(line)) |-> (status[2] == ($past(status[15:8]) == line)));

  p_match_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vmatch |-> status[2] && $past(status[5]) && (line != $past(line)));

  p_ro_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (status[7:6] == 2'b00));
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(
  .V_LINES(V_LINES),
  .TOTAL_LINES(TOTAL_LINES)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .status(status),
  .line(line),
  .state(state),
  .irq_hblank(irq_hblank),
  .irq_vblank(irq_vblank),
  .irq_vmatch(irq_vmatch),
  .render_stb(render_stb)
);

// File: tb/sim_lcd_scan_timer.sv
`timescale 1ns/1ps
module sim_lcd_scan_timer;
  localparam int PIX = 1, HPX = 8, VL = 6, VBL = 3, HB = 4;
  localparam int HD = PIX * HPX;
  localparam int LN = HD + HB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] status;
  logic [7:0]  line;
  logic [1:0]  state;
  logic        irq_hblank, irq_vblank, irq_vmatch, render_stb;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lcd_scan_timer #(.PIX_CYC(PIX), .H_PIXELS(HPX), .V_LINES(VL), .VB_LINES(VBL), .HB_CYC(HB)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .line(line), .state(state),
    .irq_hblank(irq_hblank), .irq_vblank(irq_vblank), .irq_vmatch(irq_vmatch),
    .render_stb(render_stb));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] v);
    wr_en = 1'b1;
    wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_state(input logic [1:0] s, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (state != s && n < 5000);
  endtask

  task automatic wait_line(input logic [7:0] l);
    int n = 0;
    do begin
      step();
      n++;
    end while (line != l && n < 5000);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", int'(status), 0);
    chk("R1 line", int'(line), 0);
    chk("R1 state", int'(state), 0);
    chk("R1 outputs", int'({irq_hblank, irq_vblank, irq_vmatch, render_stb}), 0);
  endtask

  task automatic t_hdraw_and_mask();
    int n;
    wait_state(2'd1, n);
    chk("R2 draw length", n, HD);
    chk("R3 hblank flag", int'(status[1]), 1);
    chk("R3 no irq when disabled", int'(irq_hblank), 0);
    wr(16'hFFFF);
    chk("R9 write ones", int'(status), 16'hFF3A);
    wr(16'h0000);
    chk("R9 write zeros keeps flags", int'(status), 16'h0002);
  endtask

  task automatic t_hblank_end();
    int n;
    do_reset();
    wait_state(2'd1, n);
    wait_state(2'd0, n);
    chk("R4 hblank length", n, HB);
    chk("R4 line advance", int'(line), 1);
    chk("R4 render strobe", int'(render_stb), 1);
    chk("R4 hblank flag clear", int'(status[1]), 0);
    step();
    chk("R4 render one cycle", int'(render_stb), 0);
  endtask

  task automatic t_hblank_irq();
    int n;
    wr(16'h0010);
    wait_state(2'd1, n);
    chk("R3 draw length line1", n + 2, HD);
    chk("R3 irq pulse", int'(irq_hblank), 1);
    step();
    chk("R3 irq one cycle", int'(irq_hblank), 0);
  endtask

  task automatic t_vblank();
    int n, n2;
    wr(16'h0018);
    wait_state(2'd2, n);
    chk("R5 line at vblank", int'(line), VL);
    chk("R5 vblank flag", int'(status[1:0]), 1);
    chk("R5 vblank irq", int'(irq_vblank), 1);
    chk("R5 no render", int'(render_stb), 0);
    n = 0;
    do begin
      step();
      n++;
    end while (line == VL && n < 5000);
    chk("R6 blank line length", n, LN);
    chk("R6 next blank line", int'({state, line}), int'({2'd2, 8'(VL + 1)}));
    wait_state(2'd0, n2);
    chk("R6 vblank span", n + n2, VBL * LN);
    chk("R6 wrap line", int'(line), 0);
    chk("R6 vblank flag clear", int'(status[0]), 0);
    chk("R6 render on wrap", int'(render_stb), 1);
  endtask

  task automatic t_compare();
    wr(16'h0220);
    wait_line(8'd2);
    chk("R7 flag on match", int'(status[2]), 1);
    chk("R8 irq visible line", int'(irq_vmatch), 1);
    step();
    chk("R8 irq one cycle", int'(irq_vmatch), 0);
    chk("R7 flag held", int'(status[2]), 1);
    wait_line(8'd3);
    chk("R7 flag clears", int'(status[2]), 0);
    wr(16'h0400);
    wait_line(8'd4);
    chk("R7 flag without enable", int'(status[2]), 1);
    chk("R8 no irq when disabled", int'(irq_vmatch), 0);
    wr(16'h0720);
    wait_line(8'd7);
    chk("R8 blank line state", int'(state), 2);
    chk("R8 irq blank line", int'({status[2], irq_vmatch}), 3);
    wr(16'h0020);
    wait_line(8'd0);
    chk("R8 wrap state", int'(state), 0);
    chk("R8 irq on wrap", int'({status[2], irq_vmatch}), 3);
  endtask

  initial begin
    t_reset();
    t_hdraw_and_mask();
    t_hblank_end();
    t_hblank_irq();
    t_vblank();
    t_compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule